// File: doc/BRIEF.md
# Bidirectional Bus Multiplexing Latch

This block links one narrow bus (side A) with two banks of equal width (bank 1 and bank 2). It carries data both ways. In the A-to-bank direction, each bank has its own transparent latch that copies A. Each bank is driven out under its own active-low enable, so either bank, both or neither can receive a word. In the bank-to-A direction, each bank input is caught in a separate transparent latch. A select input decides which of the two stored words is driven onto A, under an active-low A-side enable.

Typical uses are splitting a shared address/data path into separate address and data buses, and interleaving two memory banks behind one port. Tri-state pins are modelled as a data output plus a driven flag, which the pad ring turns into a real tri-state buffer. All four storage elements are level-sensitive latches. An active-low asynchronous reset clears all four to zero.

Top module: `ab_mux_latch`

## Requirements
- R1: While `rst_ni` is low, all four latches read zero, whatever the latch enables are. So `a_o`, `b1_o` and `b2_o` are all zero.
- R2: While `le_ab1_i` is 1, `b1_o` equals `a_i`. When `le_ab1_i` is 0, `b1_o` keeps the value `a_i` had when the enable fell.
- R3: `b2_o` behaves the same way under `le_ab2_i`, independently of bank 1. One bank can hold while the other keeps following `a_i`.
- R4: The latch on `b1_i` is transparent while `le_ba1_i` is 1 and holds while it is 0. The latch on `b2_i` does the same under `le_ba2_i`. The two are independent.
- R5: When `sel_b1_i` is 1, `a_o` shows the bank-1 return latch. When `sel_b1_i` is 0, `a_o` shows the bank-2 return latch. If the chosen latch is holding, `a_o` shows its held value.
- R6: `a_oe_o` is 1 exactly when `oe_a_ni` is 0.
- R7: `b1_oe_o` is 1 exactly when `oe_b1_ni` is 0, and `b2_oe_o` is 1 exactly when `oe_b2_ni` is 0. The two are independent. The data outputs keep their latch values whether or not their port is enabled.
- R8: When a latch enable that was low returns high, that latch follows its input again straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of all latches |
| a_i | input | 12 | Data arriving from side A |
| a_o | output | 12 | Data driven toward side A |
| a_oe_o | output | 1 | 1 while side A is driven |
| b1_i | input | 12 | Data arriving from bank 1 |
| b1_o | output | 12 | Data driven toward bank 1 |
| b1_oe_o | output | 1 | 1 while bank 1 is driven |
| b2_i | input | 12 | Data arriving from bank 2 |
| b2_o | output | 12 | Data driven toward bank 2 |
| b2_oe_o | output | 1 | 1 while bank 2 is driven |
| le_ab1_i | input | 1 | Transparent-high enable, A to bank 1 latch |
| le_ab2_i | input | 1 | Transparent-high enable, A to bank 2 latch |
| le_ba1_i | input | 1 | Transparent-high enable, bank 1 to A latch |
| le_ba2_i | input | 1 | Transparent-high enable, bank 2 to A latch |
| sel_b1_i | input | 1 | 1 picks bank 1 return latch for A, 0 picks bank 2 |
| oe_a_ni | input | 1 | Active-low drive enable for side A |
| oe_b1_ni | input | 1 | Active-low drive enable for bank 1 |
| oe_b2_ni | input | 1 | Active-low drive enable for bank 2 |

## Verification
The block has no clock, so every result is due within the same cycle as its stimulus: zero clock cycles of delay, only settling through a latch and a two-way mux. The bench changes inputs on the falling edge of its pacing clock and samples the outputs 3 ns later, before the next rising edge. Each sample therefore sees settled values and never races an input change. Hold behaviour is checked by changing a latch's input in a later row while its enable is low, and confirming that the earlier value is still there.

// File: rtl/ab_mux_latch_pkg.sv
package ab_mux_latch_pkg;
  localparam int unsigned BUS_W     = 12;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    PICK_BANK2 = 1'b0,
    PICK_BANK1 = 1'b1
  } pick_e;
endpackage

// File: rtl/bus_latch.sv
module bus_latch #(
  parameter int unsigned W = 12
) (
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // Deliberate level-sensitive storage; reset dominates the enable.
  always_latch begin
    if (!rst_ni)   q_o = '0;
    else if (en_i) q_o = d_i;
  end
endmodule

// File: rtl/bank_pick.sv
module bank_pick #(
  parameter int unsigned W = 12,
  parameter int unsigned N = 2
) (
  input  logic [N-1:0][W-1:0] word_i,
  input  logic                pick_b1_i,
  output logic [W-1:0]        word_o
);
  import ab_mux_latch_pkg::*;

  pick_e pick;

  always_comb begin
    pick   = pick_e'(pick_b1_i);
    word_o = (pick == PICK_BANK1) ? word_i[0] : word_i[1];
  end
endmodule

// File: rtl/ab_mux_latch.sv
module ab_mux_latch
  import ab_mux_latch_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b1_i,
  output logic [W-1:0] b1_o,
  output logic         b1_oe_o,
  input  logic [W-1:0] b2_i,
  output logic [W-1:0] b2_o,
  output logic         b2_oe_o,
  input  logic         le_ab1_i,
  input  logic         le_ab2_i,
  input  logic         le_ba1_i,
  input  logic         le_ba2_i,
  input  logic         sel_b1_i,
  input  logic         oe_a_ni,
  input  logic         oe_b1_ni,
  input  logic         oe_b2_ni
);
  localparam int unsigned NB = NUM_BANKS;

  logic [NB-1:0]        le_ab, le_ba, oe_b_n;
  logic [NB-1:0][W-1:0] b_in, ab_q, ba_q;

  assign le_ab  = {le_ab2_i, le_ab1_i};
  assign le_ba  = {le_ba2_i, le_ba1_i};
  assign oe_b_n = {oe_b2_ni, oe_b1_ni};
  assign b_in   = {b2_i, b1_i};

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bus_latch #(.W(W)) u_ab_latch (
      .rst_ni (rst_ni),
      .en_i   (le_ab[g]),
      .d_i    (a_i),
      .q_o    (ab_q[g])
    );

    bus_latch #(.W(W)) u_ba_latch (
      .rst_ni (rst_ni),
      .en_i   (le_ba[g]),
      .d_i    (b_in[g]),
      .q_o    (ba_q[g])
    );
  end

  bank_pick #(.W(W), .N(NB)) u_pick (
    .word_i    (ba_q),
    .pick_b1_i (sel_b1_i),
    .word_o    (a_o)
  );

  assign b1_o    = ab_q[0];
  assign b2_o    = ab_q[1];
  assign a_oe_o  = ~oe_a_ni;
  assign b1_oe_o = ~oe_b_n[0];
  assign b2_oe_o = ~oe_b_n[1];
endmodule

// File: rtl/ab_mux_latch_chk.sv
module ab_mux_latch_chk #(
  parameter int unsigned W = 12
) (
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] b1_i,
  input logic [W-1:0] b1_o,
  input logic [W-1:0] b2_i,
  input logic [W-1:0] b2_o,
  input logic         le_ab1_i,
  input logic         le_ab2_i,
  input logic         le_ba1_i,
  input logic         le_ba2_i,
  input logic         sel_b1_i
);
  always_comb begin
    if (!rst_ni) begin
      AST_RST_CLEAR: assert ((a_o == '0) && (b1_o == '0) && (b2_o == '0))
        else $error("reset did not clear latches"); // R1
    end else begin
      if (le_ab1_i) begin
        AST_B1_FOLLOW: assert (b1_o == a_i)
          else $error("bank 1 not following A"); // R2
      end
      if (le_ab2_i) begin
        AST_B2_FOLLOW: assert (b2_o == a_i)
          else $error("bank 2 not following A"); // R3
      end
      if (sel_b1_i && le_ba1_i) begin
        AST_A_FROM_B1: assert (a_o == b1_i)
          else $error("A not following bank 1"); // R5
      end
      if (!sel_b1_i && le_ba2_i) begin
        AST_A_FROM_B2: assert (a_o == b2_i)
          else $error("A not following bank 2"); // R4
      end
    end
  end
endmodule

bind ab_mux_latch ab_mux_latch_chk #(.W(W)) u_chk (
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .a_o      (a_o),
  .b1_i     (b1_i),
  .b1_o     (b1_o),
  .b2_i     (b2_i),
  .b2_o     (b2_o),
  .le_ab1_i (le_ab1_i),
  .le_ab2_i (le_ab2_i),
  .le_ba1_i (le_ba1_i),
  .le_ba2_i (le_ba2_i),
  .sel_b1_i (sel_b1_i)
);

// File: tb/ab_mux_latch_bench.sv
module ab_mux_latch_bench;
  localparam int W = 12;
  localparam int NV = 15;

  typedef struct packed {
    logic [W-1:0] a, b1, b2;
    logic [3:0]   le;    // {ba2, ba1, ab2, ab1}
    logic         sel;
    logic [2:0]   oen;   // {a, b1, b2}, active low
    logic [W-1:0] ea, eb1, eb2;
    logic [2:0]   eoe;   // {a, b1, b2}
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{12'h111, 12'h000, 12'h000, 4'b0011, 1'b1, 3'b100, 12'h000, 12'h111, 12'h111, 3'b011},
    '{12'h222, 12'h000, 12'h000, 4'b0010, 1'b1, 3'b100, 12'h000, 12'h111, 12'h222, 3'b011},
    '{12'h333, 12'h000, 12'h000, 4'b0001, 1'b1, 3'b100, 12'h000, 12'h333, 12'h222, 3'b011},
    '{12'h444, 12'h000, 12'h000, 4'b0000, 1'b1, 3'b110, 12'h000, 12'h333, 12'h222, 3'b001},
    '{12'h555, 12'h000, 12'h000, 4'b0000, 1'b1, 3'b101, 12'h000, 12'h333, 12'h222, 3'b010},
    '{12'h000, 12'h000, 12'h000, 4'b0000, 1'b1, 3'b111, 12'h000, 12'h333, 12'h222, 3'b000},
    '{12'h000, 12'hAAA, 12'hBBB, 4'b1100, 1'b1, 3'b011, 12'hAAA, 12'h333, 12'h222, 3'b100},
    '{12'h000, 12'hAAA, 12'hBBB, 4'b1100, 1'b0, 3'b011, 12'hBBB, 12'h333, 12'h222, 3'b100},
    '{12'h000, 12'hCCC, 12'hDDD, 4'b1000, 1'b1, 3'b011, 12'hAAA, 12'h333, 12'h222, 3'b100},
    '{12'h000, 12'hCCC, 12'hDDD, 4'b1000, 1'b0, 3'b011, 12'hDDD, 12'h333, 12'h222, 3'b100},
    '{12'h000, 12'hCCC, 12'hEEE, 4'b0000, 1'b0, 3'b011, 12'hDDD, 12'h333, 12'h222, 3'b100},
    '{12'h000, 12'hFFF, 12'hEEE, 4'b0100, 1'b1, 3'b011, 12'hFFF, 12'h333, 12'h222, 3'b100},
    '{12'h000, 12'hFFF, 12'hEEE, 4'b0100, 1'b1, 3'b111, 12'hFFF, 12'h333, 12'h222, 3'b000},
    '{12'h000, 12'hFFF, 12'h123, 4'b1000, 1'b0, 3'b111, 12'h123, 12'h333, 12'h222, 3'b000},
    '{12'h456, 12'hFFF, 12'h123, 4'b0010, 1'b0, 3'b111, 12'h123, 12'h333, 12'h456, 3'b000}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_ni;
  logic [W-1:0] a_i, b1_i, b2_i, a_o, b1_o, b2_o;
  logic         a_oe_o, b1_oe_o, b2_oe_o;
  logic         le_ab1_i, le_ab2_i, le_ba1_i, le_ba2_i, sel_b1_i;
  logic         oe_a_ni, oe_b1_ni, oe_b2_ni;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  ab_mux_latch u_ab_mux_latch (
    .rst_ni, .a_i, .a_o, .a_oe_o, .b1_i, .b1_o, .b1_oe_o,
    .b2_i, .b2_o, .b2_oe_o, .le_ab1_i, .le_ab2_i, .le_ba1_i, .le_ba2_i,
    .sel_b1_i, .oe_a_ni, .oe_b1_ni, .oe_b2_ni
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    a_i = v.a; b1_i = v.b1; b2_i = v.b2;
    {le_ba2_i, le_ba1_i, le_ab2_i, le_ab1_i} = v.le;
    sel_b1_i = v.sel;
    {oe_a_ni, oe_b1_ni, oe_b2_ni} = v.oen;
    #3;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 2000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_ni = 1'b0;
    apply('{12'h5A5, 12'h3C3, 12'h7E7, 4'b1111, 1'b1, 3'b111,
            12'h000, 12'h000, 12'h000, 3'b000});
    // R1: reset dominates open latches
    check("R1 a_o", a_o, '0);
    check("R1 b1_o", b1_o, '0);
    check("R1 b2_o", b2_o, '0);
    @(negedge clk);
    le_ab1_i = 1'b0; le_ab2_i = 1'b0; le_ba1_i = 1'b0; le_ba2_i = 1'b0;
    #1 rst_ni = 1'b1;
    #2;
    check("R1 b1_o held zero after reset", b1_o, '0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check("R4/R5 a_o", a_o, VECS[i].ea);                    // R4 return latches, R5 select
      check("R2 b1_o", b1_o, VECS[i].eb1);                    // R8 release in row 3
      check("R3 b2_o", b2_o, VECS[i].eb2);                    // R8 release in row 15
      check("R6 a_oe_o", {11'd0, a_oe_o}, {11'd0, VECS[i].eoe[2]});
      check("R7 b_oe", {10'd0, b1_oe_o, b2_oe_o}, {10'd0, VECS[i].eoe[1:0]});
    end

    // R8: release of the bank-1 return latch after hold
    apply('{12'h000, 12'h9AB, 12'h123, 4'b0100, 1'b1, 3'b111,
            12'h000, 12'h000, 12'h000, 3'b000});
    check("R8 a_o after release", a_o, 12'h9AB);

    // R1: reset clears latches that were holding data
    @(negedge clk);
    le_ba1_i = 1'b0;
    rst_ni = 1'b0;
    #3;
    check("R1 a_o cleared", a_o, '0);
    check("R1 b2_o cleared", b2_o, '0);

    done = 1'b1;
    summary();
  end
endmodule